// File: doc/BRIEF.md
# Decimating Tap Delay Line with Ping-Pong Reversal

This block produces the data taps for one symmetric filter cell. Incoming samples move along a forward chain of delay stages. Each stage holds up to sixteen registers, and a programmable factor picks how many of them are in use. Every forward stage therefore delays by that many shifts. The chain feeds a decimating filter, a 2-D kernel up to 16 by 16, or a fractional-rate converter.

A second, reverse chain with the same staging supplies the partner taps for pre-addition: forward tap k is paired with reverse tap k. The reverse chain is filled from one of two last-in-first-out buffers while the other buffer records the output of the forward chain. An active-low transfer strobe exchanges the two buffers. The block of samples just recorded is then played back into the reverse chain newest first, which reverses its time order. Filter arithmetic and coefficients sit outside this block.

Top module: `decim_delay_path`

## Requirements
- R1: While reset is asserted and after it is released, every forward and reverse tap reads zero, both buffers are empty and buffer 0 is the one being written.
- R2: All inputs are captured at the rising clock edge. A sample captured together with an active shift (shift_n low) enters the forward chain at the next edge. Forward tap k (tap 0 is bits 9:0) equals the sample that entered (k+1)*D shifts earlier.
- R3: When shift_n is high, no forward stage, reverse stage or buffer pointer changes, so the taps stay constant while dec_sel is unchanged.
- R4: The delay factor D is dec_sel+1, where dec_sel is 4 bits wide (0 gives 1 and 15 gives 16). After a reset and with D constant, a sample driven before edge 1 with shifting kept active appears on forward tap k exactly after edge 1+(k+1)*D.
- R5: Each shift pushes the value that the last forward tap holds before that shift into the buffer being written. The buffer holds at most 16 entries, and pushes beyond that are dropped.
- R6: A captured low on xfer_n exchanges the buffers after any push of the same cycle is done. The buffer just written becomes the read buffer with its full contents, and the write and read positions restart at zero.
- R7: Each shift pops the read buffer newest entry first into the reverse chain. Once the buffer is exhausted, and before the first exchange, zeros enter instead.
- R8: The reverse chain uses the same factor D as the forward chain. Reverse tap k equals the value popped (k+1)*D shifts earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| sample_in | input | 10 | Incoming sample |
| shift_n | input | 1 | Active-low shift enable |
| xfer_n | input | 1 | Active-low buffer exchange strobe |
| dec_sel | input | 4 | Delay factor minus one |
| fwd_taps | output | 40 | Four forward taps, tap k in bits 10k+9:10k |
| rev_taps | output | 40 | Four reverse taps, tap k in bits 10k+9:10k |

## Verification
The assertions assume that rst_n is released away from the clock edge and that the strobes are clean levels sampled at each edge. Beyond that they accept any mix of shift, exchange and factor, including an exchange in the same cycle as a shift and pushes into a full buffer. The stimulus drives every input at the falling edge. It holds the factor steady for long stretches and changes it only occasionally, and it sends bursts of more than sixteen shifts between exchanges so that the full-buffer and empty-buffer paths are both reached.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int SAMPLE_W = 10;
  localparam int TAP_N    = 4;
  localparam int DEC_MAX  = 16;
  localparam int LIFO_D   = 16;
endpackage

// File: rtl/dly_chain.sv
module dly_chain #(
  parameter int DW    = 10,
  parameter int NTAP  = 4,
  parameter int DEPTH = 16,
  localparam int SW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic [SW-1:0]      sel,
  input  logic [DW-1:0]      din,
  output logic [NTAP*DW-1:0] taps
);
  logic [DW-1:0] stg_q [NTAP][DEPTH];
  logic [DW-1:0] stg_n [NTAP][DEPTH];
  logic [DW-1:0] feed  [NTAP];

  for (genvar k = 0; k < NTAP; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign feed[k] = din;
    end else begin : g_link
      assign feed[k] = stg_q[k-1][sel];
    end
    assign taps[k*DW +: DW] = stg_q[k][sel];
  end

  always_comb begin
    for (int k = 0; k < NTAP; k++) begin
      stg_n[k][0] = feed[k];
      for (int i = 1; i < DEPTH; i++) stg_n[k][i] = stg_q[k][i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAP; k++)
        for (int i = 0; i < DEPTH; i++) stg_q[k][i] <= '0;
    end else if (shift_en) begin
      stg_q <= stg_n;
    end
  end

  // R3: an idle cycle leaves the chain head untouched
  a_r3_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stg_q[0][0]));
  // R2: a shift loads the head with the value offered
  a_r2_head_load: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stg_q[0][0] == $past(din));
endmodule

// File: rtl/dly_lifo_pair.sv
module dly_lifo_pair #(
  parameter int DW    = 10,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          swap,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [DW-1:0] mem_q [2][DEPTH];
  logic          wsel_q, wsel_n;
  logic [PW-1:0] wptr_q, wptr_n, rcnt_q, rcnt_n, fill_q, fill_n;
  logic          can_push, can_pop, avail;
  logic [AW-1:0] ridx;

  assign avail    = rcnt_q < fill_q;
  assign can_push = push && (wptr_q < FULL);
  assign can_pop  = pop && avail;
  assign ridx     = AW'(fill_q - rcnt_q - PW'(1));
  assign rdata    = avail ? mem_q[~wsel_q][ridx] : '0;

  always_comb begin
    wsel_n = wsel_q;
    wptr_n = wptr_q;
    rcnt_n = rcnt_q;
    fill_n = fill_q;
    if (can_push) wptr_n = wptr_q + PW'(1);
    if (can_pop)  rcnt_n = rcnt_q + PW'(1);
    if (swap) begin
      fill_n = wptr_n;
      wsel_n = ~wsel_q;
      wptr_n = '0;
      rcnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= 1'b0;
      wptr_q <= '0;
      rcnt_q <= '0;
      fill_q <= '0;
    end else begin
      wsel_q <= wsel_n;
      wptr_q <= wptr_n;
      rcnt_q <= rcnt_n;
      fill_q <= fill_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < DEPTH; i++) mem_q[b][i] <= '0;
    end else if (can_push) begin
      mem_q[wsel_q][wptr_q[AW-1:0]] <= wdata;
    end
  end

  // R5: the write position never runs past the buffer depth
  a_r5_wptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q <= FULL);
  // R6: an exchange restarts both positions
  a_r6_swap_clear: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (wptr_q == '0 && rcnt_q == '0));
  // R6: without a same-cycle push the read length is the old write count
  a_r6_fill_take: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !push) |=> fill_q == $past(wptr_q));
  // R6: the buffer roles flip on every exchange
  a_r6_bank_flip: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> wsel_q != $past(wsel_q));
  // R7: pops never exceed what the read buffer holds
  a_r7_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt_q <= fill_q);
endmodule

// File: rtl/decim_delay_path.sv
module decim_delay_path #(
  parameter int DW      = dly_pkg::SAMPLE_W,
  parameter int NTAP    = dly_pkg::TAP_N,
  parameter int DEC_MAX = dly_pkg::DEC_MAX,
  parameter int LIFO_D  = dly_pkg::LIFO_D,
  localparam int DSW    = $clog2(DEC_MAX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DW-1:0]      sample_in,
  input  logic               shift_n,
  input  logic               xfer_n,
  input  logic [DSW-1:0]     dec_sel,
  output logic [NTAP*DW-1:0] fwd_taps,
  output logic [NTAP*DW-1:0] rev_taps
);
  logic [DW-1:0]      sample_q;
  logic               shift_q, xfer_q;
  logic [DSW-1:0]     dec_q;
  logic [DW-1:0]      lifo_rd;
  logic [NTAP*DW-1:0] chain_taps [2];
  logic [DW-1:0]      chain_din  [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      shift_q  <= 1'b0;
      xfer_q   <= 1'b0;
      dec_q    <= '0;
    end else begin
      sample_q <= sample_in;
      shift_q  <= ~shift_n;
      xfer_q   <= ~xfer_n;
      dec_q    <= dec_sel;
    end
  end

  assign chain_din[0] = sample_q;
  assign chain_din[1] = lifo_rd;

  for (genvar g = 0; g < 2; g++) begin : g_chain
    dly_chain #(.DW(DW), .NTAP(NTAP), .DEPTH(DEC_MAX)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_q),
      .sel      (dec_q),
      .din      (chain_din[g]),
      .taps     (chain_taps[g])
    );
  end

  dly_lifo_pair #(.DW(DW), .DEPTH(LIFO_D)) u_lifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (shift_q),
    .pop   (shift_q),
    .swap  (xfer_q),
    .wdata (chain_taps[0][(NTAP-1)*DW +: DW]),
    .rdata (lifo_rd)
  );

  assign fwd_taps = chain_taps[0];
  assign rev_taps = chain_taps[1];

  // R3: with no shift and a steady factor the forward taps hold
  a_r3_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_q && dec_q == dec_sel) |=> $stable(fwd_taps));
  // R3: the same holds for the reverse taps
  a_r3_rev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_q && dec_q == dec_sel) |=> $stable(rev_taps));
endmodule

// File: tb/decim_delay_path_test.sv
module decim_delay_path_test;
  localparam int W = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] sample_in;
  logic         shift_n, xfer_n;
  logic [3:0]   dec_sel;
  logic [N*W-1:0] fwd_taps, rev_taps;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  decim_delay_path uut (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .shift_n(shift_n),
    .xfer_n(xfer_n), .dec_sel(dec_sel), .fwd_taps(fwd_taps), .rev_taps(rev_taps)
  );

  always #2 clk = ~clk;

  // bench model state
  logic [W-1:0] mf [N][16];
  logic [W-1:0] mr [N][16];
  logic [W-1:0] ml [2][16];
  int mwsel, mwptr, mrcnt, mfill;
  logic [W-1:0] q_s;
  bit q_sh, q_x;
  logic [3:0] q_dec;

  task automatic model_edge();
    int d;
    logic [W-1:0] push_v, pop_v;
    if (!rst_n) begin
      for (int k = 0; k < N; k++)
        for (int i = 0; i < 16; i++) begin mf[k][i] = '0; mr[k][i] = '0; end
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < 16; i++) ml[b][i] = '0;
      mwsel = 0; mwptr = 0; mrcnt = 0; mfill = 0;
      q_s = '0; q_sh = 0; q_x = 0; q_dec = '0;
      return;
    end
    d = int'(q_dec) + 1;
    if (q_sh) begin
      push_v = mf[N-1][d-1];
      if (mwptr < 16) begin ml[mwsel][mwptr] = push_v; mwptr++; end
      pop_v = '0;
      if (mrcnt < mfill) begin pop_v = ml[1-mwsel][mfill-1-mrcnt]; mrcnt++; end
      for (int k = N-1; k >= 0; k--) begin
        for (int i = 15; i >= 1; i--) begin mf[k][i] = mf[k][i-1]; mr[k][i] = mr[k][i-1]; end
        mf[k][0] = (k == 0) ? q_s : mf[k-1][d-1];
        mr[k][0] = (k == 0) ? pop_v : mr[k-1][d-1];
      end
    end
    if (q_x) begin mfill = mwptr; mwsel = 1 - mwsel; mwptr = 0; mrcnt = 0; end
    q_s = sample_in; q_sh = !shift_n; q_x = !xfer_n; q_dec = dec_sel;
  endtask

  always @(posedge clk) model_edge();

  task automatic check_val(input string tag, input string what, input int k,
                           input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s tap %0d actual=%h expected=%h", tag, what, k, act, exp);
    end
  endtask

  task automatic cmp_model(input string tf, input string tr);
    for (int k = 0; k < N; k++) begin
      check_val(tf, "fwd", k, fwd_taps[k*W +: W], mf[k][q_dec]);
      check_val(tr, "rev", k, rev_taps[k*W +: W], mr[k][q_dec]);
    end
  endtask

  task automatic step(input logic [W-1:0] s, input bit sh_n, input bit x_n, input logic [3:0] ds);
    sample_in = s; shift_n = sh_n; xfer_n = x_n; dec_sel = ds;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_in = '0; shift_n = 1'b1; xfer_n = 1'b1; dec_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [N*W-1:0] hold_f, hold_r;
    void'($urandom(32'd5321));
    rst_n = 1'b0;
    sample_in = '0; shift_n = 1'b1; xfer_n = 1'b1; dec_sel = '0;
    do_reset();
    @(negedge clk);
    // R1: everything clear after reset
    for (int k = 0; k < N; k++) begin
      check_val("R1", "fwd", k, fwd_taps[k*W +: W], '0);
      check_val("R1", "rev", k, rev_taps[k*W +: W], '0);
    end

    // R4: impulse timing at factor 3
    step(10'h000, 1'b1, 1'b1, 4'd2);
    do_reset();
    @(negedge clk);
    for (int c = 1; c <= 13; c++) begin
      step((c == 1) ? 10'h155 : 10'h000, 1'b0, 1'b1, 4'd2);
      for (int k = 0; k < N; k++)
        check_val("R4", "fwd", k, fwd_taps[k*W +: W],
                  (c == 1 + 3*(k+1)) ? 10'h155 : 10'h000);
    end

    // R7: no exchange yet, so zeros feed the reverse chain
    for (int c = 0; c < 8; c++) begin
      step(W'($urandom), 1'b0, 1'b1, 4'd0);
      for (int k = 0; k < N; k++) check_val("R7", "rev", k, rev_taps[k*W +: W], '0);
    end

    // R3: idle cycles freeze every tap
    step(W'($urandom), 1'b1, 1'b1, 4'd0);
    hold_f = fwd_taps; hold_r = rev_taps;
    for (int c = 0; c < 5; c++) begin
      step(W'($urandom), 1'b1, 1'b1, 4'd0);
      for (int k = 0; k < N; k++) begin
        check_val("R3", "fwd", k, fwd_taps[k*W +: W], hold_f[k*W +: W]);
        check_val("R3", "rev", k, rev_taps[k*W +: W], hold_r[k*W +: W]);
      end
    end

    // R5 R6 R7: overfill, exchange during a shift, then drain past empty
    for (int c = 0; c < 22; c++) begin step(W'(c + 1), 1'b0, 1'b1, 4'd0); cmp_model("R2", "R8"); end
    step(10'h3aa, 1'b0, 1'b0, 4'd0); cmp_model("R6", "R6");
    for (int c = 0; c < 24; c++) begin step(W'($urandom), 1'b0, 1'b1, 4'd0); cmp_model("R5", "R7"); end
    step(10'h011, 1'b1, 1'b0, 4'd0); cmp_model("R6", "R6");
    for (int c = 0; c < 30; c++) begin step(W'($urandom), 1'b0, 1'b1, 4'd0); cmp_model("R2", "R7"); end

    // R8: largest factor with a short exchange period
    for (int c = 0; c < 200; c++) begin
      step(W'($urandom), 1'b0, (c % 9 == 8) ? 1'b0 : 1'b1, 4'd15);
      cmp_model("R4", "R8");
    end

    // R2 R8: random mix of shifts, exchanges and factor changes
    begin
      logic [3:0] ds = 4'd4;
      for (int c = 0; c < 4000; c++) begin
        if ($urandom % 250 == 0) ds = 4'($urandom);
        step(W'($urandom), ($urandom % 4) == 0, ($urandom % 30) != 0, ds);
        cmp_model("R2", "R8");
      end
    end
    finish_up();
  end
endmodule